// File: doc/BRIEF.md
# Sample-Clock Ratio Tracker and Realignment Sequencer

This block runs on the converter's master clock. It watches the frame (word) clock and the serial bit clock. It works out whether the master clock runs at 256 or 384 times the frame rate. It keeps an internal per-sample timer in phase with the incoming frame clock and sequences the start-up wait after power becomes good. The downstream datapath takes three things from it: a one-cycle sample strobe, the detected ratio, and a flag that forces the output to midscale.

Both incoming clocks pass through two-flop synchronizers, and the block then detects their rising edges. At each frame-clock edge, the number of master-clock cycles since the previous edge is sorted into one of three classes: the low ratio, the high ratio, or invalid. At each frame-clock edge, the block also counts the bit-clock edges seen since the internal sample strobe. That count, taken modulo the bits per frame, is the phase error in bit-clock units.

The controller has four states. In `INIT` it waits a fixed number of cycles after power is good, then moves to `ACQUIRE`. In `ACQUIRE`, two consecutive periods of the same valid class load the ratio, realign the timer and move to `RESYNC`. `RESYNC` goes to `RUN` at the next sample strobe. It goes back to `ACQUIRE` if a period does not match the held ratio. `RUN` goes to `ACQUIRE` when a period does not match the held ratio. It goes to `RESYNC`, and realigns the timer, when the phase error exceeds the limit. The midscale flag is low only in `RUN`.

Top module: `fs_ratio_tracker`

## Requirements
- R1: After `pwr_good` goes high, `force_mid` stays 1 for at least INIT_CYCLES (default 1024) master-clock cycles.
- R2: While `pwr_good` is low, the outputs read `force_mid`=1, `ratio_locked`=0, `ratio_hi`=0 and `sample_stb`=0.
- R3: A frame period of 256±4 master cycles means ratio_hi=0. A period of 384±4 cycles means ratio_hi=1. After two consecutive periods of the same class, `ratio_locked` goes to 1, and one frame later `force_mid` goes to 0.
- R4: A frame period outside both windows clears `ratio_locked` and sets `force_mid`, and `ratio_hi` keeps its value. Two matching valid periods restore lock.
- R5: A single period of the other valid class does not change `ratio_hi`, and it clears `ratio_locked`. Two consecutive such periods switch `ratio_hi`.
- R6: When locked and aligned, `sample_stb` is a one-cycle pulse every 256 (ratio_hi=0) or 384 (ratio_hi=1) cycles. The pulse falls within three cycles of the frame-clock rising edge.
- R7: A phase error of at most 6 bit-clock periods causes no realignment. A larger error sets `force_mid` while `ratio_locked` stays 1.
- R8: After a realignment, `force_mid` stays high for one full sample period and falls in the cycle after a `sample_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256 or 384 times the frame rate) |
| pwr_good | input | 1 | Active-low asynchronous reset; high once supply is good |
| wclk_in | input | 1 | Frame (word) clock, asynchronous |
| bclk_in | input | 1 | Serial bit clock, asynchronous, BCK_PER_FS edges per frame |
| ratio_hi | output | 1 | 1 when the master clock is 384x, 0 when 256x |
| ratio_locked | output | 1 | Ratio confirmed and the controller is in RESYNC or RUN |
| sample_stb | output | 1 | One-cycle internal sample-rate strobe |
| force_mid | output | 1 | Force the downstream output to midscale |

## Verification
The assertions assume three things about the inputs. The frame clock runs freely with periods of at least 256 master cycles. The bit clock toggles at a fixed integer division of the frame period. `pwr_good` only drops as a whole reset of the block. The bench meets these assumptions by building both clocks from one counter on the master clock's falling edge. The frame length can be changed only at a frame boundary: it is set to 256, 384, a slowly drifting 259, or an invalid 300. The bit-clock division is always tied to the selected ratio.

// File: rtl/fsrt_pkg.sv
package fsrt_pkg;

    typedef enum logic [1:0] {
        CLS_BAD = 2'd0,
        CLS_LO  = 2'd1,
        CLS_HI  = 2'd2
    } ratio_cls_e;

    typedef enum logic [1:0] {
        ST_INIT    = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_RESYNC  = 2'd2,
        ST_RUN     = 2'd3
    } trk_state_e;

endpackage

// File: rtl/fsrt_edge_sync.sv
module fsrt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsrt_period_class.sv
module fsrt_period_class
    import fsrt_pkg::*;
#(
    parameter int RATIO_LO  = 256,
    parameter int RATIO_HI  = 384,
    parameter int RATIO_TOL = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_rise,
    output ratio_cls_e cls,
    output logic       confirm
);
    localparam int CW = $clog2(RATIO_HI + RATIO_TOL + 2);
    localparam logic [CW-1:0] LO_MIN = CW'(RATIO_LO - RATIO_TOL);
    localparam logic [CW-1:0] LO_MAX = CW'(RATIO_LO + RATIO_TOL);
    localparam logic [CW-1:0] HI_MIN = CW'(RATIO_HI - RATIO_TOL);
    localparam logic [CW-1:0] HI_MAX = CW'(RATIO_HI + RATIO_TOL);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] per_cnt;
    logic          seen_edge;
    ratio_cls_e    prev_cls;
    ratio_cls_e    cls_now;

    always_comb begin
        if (!seen_edge)
            cls_now = CLS_BAD;
        else if (per_cnt >= LO_MIN && per_cnt <= LO_MAX)
            cls_now = CLS_LO;
        else if (per_cnt >= HI_MIN && per_cnt <= HI_MAX)
            cls_now = CLS_HI;
        else
            cls_now = CLS_BAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt   <= '0;
            seen_edge <= 1'b0;
            prev_cls  <= CLS_BAD;
        end else if (edge_rise) begin
            per_cnt   <= CW'(1);
            seen_edge <= 1'b1;
            prev_cls  <= cls_now;
        end else if (per_cnt != CNT_MAX) begin
            per_cnt   <= per_cnt + CW'(1);
        end
    end

    assign cls     = cls_now;
    assign confirm = edge_rise && (cls_now != CLS_BAD) && (cls_now == prev_cls);
endmodule

// File: rtl/fsrt_sample_timer.sv
module fsrt_sample_timer #(
    parameter int RATIO_LO   = 256,
    parameter int RATIO_HI   = 384,
    parameter int BCK_PER_FS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          use_hi,
    input  logic                          realign,
    input  logic                          bclk_rise,
    output logic                          stb,
    output logic [$clog2(BCK_PER_FS):0]   bit_err
);
    localparam int TW = $clog2(RATIO_HI);
    localparam int BW = $clog2(BCK_PER_FS);
    localparam logic [TW-1:0] LAST_LO = TW'(RATIO_LO - 1);
    localparam logic [TW-1:0] LAST_HI = TW'(RATIO_HI - 1);
    localparam logic [BW:0]   HALF    = (BW+1)'(BCK_PER_FS / 2);
    localparam logic [BW:0]   FULL    = (BW+1)'(BCK_PER_FS);

    logic [TW-1:0] smp_cnt;
    logic [BW-1:0] bit_cnt;
    logic [TW-1:0] last;
    logic [BW:0]   bit_ext;
    logic [BW-1:0] rise_inc;

    assign last     = use_hi ? LAST_HI : LAST_LO;
    assign stb      = (smp_cnt >= last);
    assign rise_inc = {{(BW-1){1'b0}}, bclk_rise};
    assign bit_ext  = {1'b0, bit_cnt};
    assign bit_err  = (bit_ext <= HALF) ? bit_ext : (FULL - bit_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            bit_cnt <= '0;
        end else begin
            smp_cnt <= (realign || stb) ? '0 : smp_cnt + TW'(1);
            bit_cnt <= (realign || stb) ? rise_inc : bit_cnt + rise_inc;
        end
    end
endmodule

// File: rtl/fs_ratio_tracker.sv
module fs_ratio_tracker
    import fsrt_pkg::*;
#(
    parameter int RATIO_LO    = 256,
    parameter int RATIO_HI    = 384,
    parameter int RATIO_TOL   = 4,
    parameter int BCK_PER_FS  = 32,
    parameter int PHASE_LIMIT = 6,
    parameter int INIT_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic wclk_in,
    input  logic bclk_in,
    output logic ratio_hi,
    output logic ratio_locked,
    output logic sample_stb,
    output logic force_mid
);
    localparam int EW = $clog2(BCK_PER_FS) + 1;
    localparam int IW = $clog2(INIT_CYCLES);
    localparam logic [EW-1:0] ERR_LIM   = EW'(PHASE_LIMIT);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

    logic          w_rise;
    logic          b_rise;
    ratio_cls_e    w_cls;
    logic          w_confirm;
    logic [EW-1:0] bit_err;
    logic          stb;
    trk_state_e    state_q, state_n;
    logic          realign;
    logic          load_ratio;
    logic          hi_q;
    logic [IW-1:0] init_cnt;
    logic          cls_match;

    fsrt_edge_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst_n(pwr_good), .async_in(wclk_in), .rise(w_rise)
    );

    fsrt_edge_sync #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk(clk), .rst_n(pwr_good), .async_in(bclk_in), .rise(b_rise)
    );

    fsrt_period_class #(
        .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .RATIO_TOL(RATIO_TOL)
    ) u_class (
        .clk(clk), .rst_n(pwr_good), .edge_rise(w_rise),
        .cls(w_cls), .confirm(w_confirm)
    );

    fsrt_sample_timer #(
        .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .BCK_PER_FS(BCK_PER_FS)
    ) u_timer (
        .clk(clk), .rst_n(pwr_good), .use_hi(hi_q), .realign(realign),
        .bclk_rise(b_rise), .stb(stb), .bit_err(bit_err)
    );

    assign cls_match = (w_cls == (hi_q ? CLS_HI : CLS_LO));

    // Next-state decisions
    always_comb begin
        state_n    = state_q;
        realign    = 1'b0;
        load_ratio = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                if (init_cnt == INIT_LAST)
                    state_n = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (w_confirm) begin
                    state_n    = ST_RESYNC;
                    realign    = 1'b1;
                    load_ratio = 1'b1;
                end
            end
            ST_RESYNC: begin
                if (w_rise && !cls_match)
                    state_n = ST_ACQUIRE;
                else if (stb)
                    state_n = ST_RUN;
            end
            ST_RUN: begin
                if (w_rise && !cls_match) begin
                    state_n = ST_ACQUIRE;
                end else if (w_rise && (bit_err > ERR_LIM)) begin
                    state_n = ST_RESYNC;
                    realign = 1'b1;
                end
            end
            default: state_n = ST_INIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state_q  <= ST_INIT;
            hi_q     <= 1'b0;
            init_cnt <= '0;
        end else begin
            state_q <= state_n;
            if (load_ratio)
                hi_q <= (w_cls == CLS_HI);
            if (state_q == ST_INIT)
                init_cnt <= init_cnt + IW'(1);
        end
    end

    // Outputs
    always_comb begin
        force_mid    = (state_q != ST_RUN);
        ratio_locked = (state_q == ST_RESYNC) || (state_q == ST_RUN);
        ratio_hi     = hi_q;
        sample_stb   = stb;
    end
endmodule

// File: rtl/fsrt_checker.sv
module fsrt_checker #(
    parameter int INIT_CYCLES = 1024
) (
    input logic clk,
    input logic pwr_good,
    input logic ratio_hi,
    input logic ratio_locked,
    input logic sample_stb,
    input logic force_mid
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good)
            since_rst <= '0;
        else if (since_rst != LIMIT)
            since_rst <= since_rst + CW'(1);
    end

    a_r1_init_hold: assert property (@(posedge clk) disable iff (!pwr_good)
        (since_rst < LIMIT) |-> force_mid);

    a_r4_unlocked_forced: assert property (@(posedge clk) disable iff (!pwr_good)
        !ratio_locked |-> force_mid);

    a_r5_ratio_change_locked: assert property (@(posedge clk) disable iff (!pwr_good)
        !$stable(ratio_hi) |-> (ratio_locked && force_mid));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!pwr_good)
        sample_stb |=> !sample_stb);

    a_r8_release_on_strobe: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(force_mid) |-> (ratio_locked && $past(sample_stb)));
endmodule

bind fs_ratio_tracker fsrt_checker #(.INIT_CYCLES(INIT_CYCLES)) u_fsrt_checker (
    .clk(clk),
    .pwr_good(pwr_good),
    .ratio_hi(ratio_hi),
    .ratio_locked(ratio_locked),
    .sample_stb(sample_stb),
    .force_mid(force_mid)
);

// File: tb/fs_ratio_tracker_bench.sv
module fs_ratio_tracker_bench;
    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic wclk_in = 1'b0;
    logic bclk_in = 1'b0;
    logic ratio_hi, ratio_locked, sample_stb, force_mid;

    int n_cmp = 0;
    int n_bad = 0;
    int gen_period = 256;
    int gen_bper = 8;
    int gen_cnt = 0;
    int frames = 0;

    fs_ratio_tracker u_fs_ratio_tracker (
        .clk(clk), .pwr_good(pwr_good), .wclk_in(wclk_in), .bclk_in(bclk_in),
        .ratio_hi(ratio_hi), .ratio_locked(ratio_locked),
        .sample_stb(sample_stb), .force_mid(force_mid)
    );

    initial forever #10 clk = ~clk;

    // Frame and bit clock generator, driven on the falling edge
    initial forever begin
        @(negedge clk);
        gen_cnt = (gen_cnt + 1 >= gen_period) ? 0 : gen_cnt + 1;
        if (gen_cnt == 0) frames = frames + 1;
        wclk_in = (gen_cnt < gen_period / 2);
        bclk_in = ((gen_cnt % gen_bper) < gen_bper / 2);
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi,
                             input string what);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < n; i++) begin
            int f = frames;
            while (frames == f) @(posedge clk);
        end
        repeat (10) @(posedge clk);
        #5;
    endtask

    task automatic to_boundary();
        int f = frames;
        while (frames == f) @(posedge clk);
    endtask

    task automatic t_reset_state();
        pwr_good = 1'b0;
        repeat (5) tick();
        check("R2", force_mid, 1, "force_mid in reset");
        check("R2", ratio_locked, 0, "ratio_locked in reset");
        check("R2", ratio_hi, 0, "ratio_hi in reset");
        check("R2", sample_stb, 0, "sample_stb in reset");
    endtask

    task automatic t_init_hold();
        int low_seen = 0;
        @(negedge clk);
        pwr_good = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            tick();
            if (!force_mid) low_seen++;
        end
        check("R1", low_seen, 0, "cycles with force_mid low during init");
    endtask

    task automatic t_lock(input string req, input int exp_hi);
        int n = 0;
        while (force_mid && n < 4000) begin
            tick();
            n++;
        end
        check(req, force_mid, 0, "force_mid after lock");
        check(req, ratio_locked, 1, "ratio_locked after lock");
        check(req, ratio_hi, exp_hi, "ratio_hi after lock");
    endtask

    task automatic t_strobe(input int exp_gap);
        int gap = 0;
        while (!sample_stb) tick();
        check_rng("R6", gen_cnt, 1, 3, "frame position of strobe");
        tick();
        gap = 1;
        while (!sample_stb && gap < 1000) begin
            tick();
            gap++;
        end
        check("R6", gap, exp_gap, "strobe spacing");
    endtask

    task automatic t_small_drift();
        int hi_seen = 0;
        to_boundary();
        gen_period = 259;
        for (int i = 0; i < 6; i++) begin
            int f = frames;
            while (frames == f) begin
                tick();
                if (force_mid) hi_seen++;
            end
        end
        gen_period = 256;
        for (int i = 0; i < 1024; i++) begin
            tick();
            if (force_mid) hi_seen++;
        end
        check("R7", hi_seen, 0, "cycles forced under small phase error");
    endtask

    task automatic t_large_drift();
        int n = 0;
        int held = 0;
        to_boundary();
        gen_period = 259;
        while (!force_mid && n < 40 * 259) begin
            tick();
            n++;
        end
        gen_period = 256;
        check("R7", force_mid, 1, "force_mid after large phase error");
        check("R7", ratio_locked, 1, "ratio_locked kept during realign");
        held = 1;
        while (force_mid && held < 2000) begin
            tick();
            held++;
        end
        check_rng("R8", held, 255, 257, "cycles forced after realign");
    endtask

    task automatic t_bad_period();
        to_boundary();
        gen_period = 300;
        to_boundary();
        gen_period = 256;
        repeat (10) tick();
        check("R4", ratio_locked, 0, "ratio_locked after invalid period");
        check("R4", force_mid, 1, "force_mid after invalid period");
        check("R4", ratio_hi, 0, "ratio_hi kept after invalid period");
        wait_frames(4);
        check("R4", force_mid, 0, "force_mid after recovery");
        check("R4", ratio_locked, 1, "ratio_locked after recovery");
    endtask

    task automatic t_ratio_change();
        to_boundary();
        gen_period = 384;
        gen_bper = 12;
        wait_frames(1);
        check("R5", ratio_hi, 0, "ratio_hi after one new period");
        check("R5", ratio_locked, 0, "ratio_locked after one new period");
        wait_frames(1);
        check("R5", ratio_hi, 1, "ratio_hi after two new periods");
        check("R5", ratio_locked, 1, "ratio_locked after two new periods");
        check("R5", force_mid, 1, "force_mid while realigning");
        wait_frames(1);
        check("R3", force_mid, 0, "force_mid one frame after 384 lock");
    endtask

    task automatic t_reset_midrun();
        @(negedge clk);
        pwr_good = 1'b0;
        repeat (3) tick();
        check("R2", force_mid, 1, "force_mid in mid-run reset");
        check("R2", ratio_locked, 0, "ratio_locked in mid-run reset");
        check("R2", ratio_hi, 0, "ratio_hi in mid-run reset");
        t_init_hold();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_init_hold();
        t_lock("R3", 0);
        t_strobe(256);
        t_small_drift();
        t_large_drift();
        t_bad_period();
        t_ratio_change();
        t_strobe(384);
        t_reset_midrun();
        t_lock("R3", 1);
        finish_run();
    end
endmodule